// File: doc/BRIEF.md
# Power-Sequencing Protocol Monitor

This block watches the power-control signals of a small group of switchable domains. On every rising clock edge it checks the order of events between the power switch, its acknowledge, the isolation clamp and the retention restore. It also checks that the combined on/off pattern of the domains is one of the system states software has declared legal. It models neither supply corruption nor voltage. It judges only the order of events and the legality of each state, one clock edge at a time.

Each kind of violation sets its own sticky flag. For every cycle in which at least one violation is detected, the monitor records the lowest-numbered violation of that cycle and the value of a free-running cycle counter. A legal-state table of up to eight entries holds one on/off mask per entry, with one bit per domain. Software fills it through a write port while checking is switched off. Whenever the acknowledged on/off vector moves between two legal states, a saturating counter for that (from, to) pair of table indices advances. This shows which sleep and wake paths a test has exercised.

Top module: `pwr_seq_monitor`

## Requirements
- R1: After reset, err_flags, err_code, err_time and every coverage counter read zero, and every table entry is invalid. A synchronous clr clears the flags, the code, the time, the cycle counter and all coverage counters, and leaves the table unchanged.
- R2: Flag bit 0 (code 0) is set when a domain's pwr_en goes from 1 to 0 while that domain's iso_en is 0.
- R3: Flag bit 1 (code 1) is set when a domain's pwr_en goes from 0 to 1 while that domain's iso_en is 0.
- R4: A domain's restore is pending from the rising edge of its pwr_en until ret_restore is seen high for it. Flag bit 2 (code 2) is set when iso_en goes from 1 to 0 while the restore is pending. Releasing isolation after the restore raises no flag.
- R5: Flag bit 3 (code 3) is set when a domain's dom_ready is 1 while its pwr_ack is 0.
- R6: Flag bit 4 (code 4) is set when the pwr_ack vector (bit d is domain d) equals no valid table entry's mask.
- R7: Flags are sticky until clr. In each cycle with at least one new violation, err_code takes the lowest violated bit number and err_time takes the cycle count before that edge. The cycle count is the number of edges since the last reset or clr.
- R8: While chk_en is 0, no flag is set and no coverage counter moves.
- R9: A table write (tbl_we) stores tbl_mask and tbl_valid at tbl_addr only while chk_en is 0. A write while chk_en is 1 is ignored.
- R10: A state's index is the lowest valid table entry whose mask matches it. When pwr_ack changes and both the old and the new vectors are legal, the counter for (old index, new index) increments and saturates at its maximum. Moves into or out of an illegal vector are not counted.
- R11: cov_count shows, combinationally, the counter selected by cov_rd_from and cov_rd_to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of flags, error record and counters |
| chk_en | input | 1 | Enables checking and coverage |
| tbl_we | input | 1 | Legal-state table write strobe |
| tbl_addr | input | TBL_AW | Table entry to write |
| tbl_mask | input | NUM_DOM | On/off mask to store |
| tbl_valid | input | 1 | Valid bit to store |
| pwr_en | input | NUM_DOM | Power-switch enable per domain |
| pwr_ack | input | NUM_DOM | Power-switch acknowledge per domain (domain on) |
| iso_en | input | NUM_DOM | Isolation enable per domain |
| ret_restore | input | NUM_DOM | Retention restore per domain |
| dom_ready | input | NUM_DOM | Domain output-valid indicator |
| cov_rd_from | input | TBL_AW | Coverage read: source state index |
| cov_rd_to | input | TBL_AW | Coverage read: destination state index |
| err_flags | output | 5 | Sticky violation flags |
| err_code | output | 3 | Lowest violation of the last violating cycle |
| err_time | output | CYC_W | Cycle count of the last violating cycle |
| cov_count | output | CNT_W | Selected transition counter |

## Verification
The properties assume that inputs change only between clock edges and that reset is held for at least one edge before the first sampled cycle. This is what lets each edge-detection property take its previous-cycle value from a defined sample. They also assume that clr is not asserted in the cycle under test, because a clear overrides a violation. The stimulus drives every input shortly after a rising edge. It starts each scenario by parking the domains in a safe state (isolated, off, restore acknowledged) and then clearing. It raises clr only in those clearing steps, so each violation under test appears alone or in a deliberately paired combination.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    localparam int NUM_ERR = 5;

    // Bit positions in the sticky flag vector; lower number wins the code.
    localparam int ERR_OFF_NO_ISO = 0;
    localparam int ERR_ON_NO_ISO  = 1;
    localparam int ERR_ISO_EARLY  = 2;
    localparam int ERR_RDY_NO_ACK = 3;
    localparam int ERR_BAD_STATE  = 4;

    typedef logic [NUM_ERR-1:0] err_vec_t;

    typedef struct packed {
        logic [NUM_ERR-1:0] flags;
        logic [2:0]         code;
    } err_rec_t;

    function automatic logic [2:0] lowest_err(input err_vec_t v);
        logic [2:0] r;
        r = '0;
        for (int i = NUM_ERR - 1; i >= 0; i--) begin
            if (v[i]) r = 3'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/pwr_seq_rules.sv
module pwr_seq_rules #(
    parameter int NUM_DOM = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_DOM-1:0] pwr_en,
    input  logic [NUM_DOM-1:0] pwr_ack,
    input  logic [NUM_DOM-1:0] iso_en,
    input  logic [NUM_DOM-1:0] ret_restore,
    input  logic [NUM_DOM-1:0] dom_ready,
    output logic [NUM_DOM-1:0] off_no_iso,
    output logic [NUM_DOM-1:0] on_no_iso,
    output logic [NUM_DOM-1:0] iso_early,
    output logic [NUM_DOM-1:0] rdy_no_ack
);

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        logic en_q;
        logic iso_q;
        logic restore_pend;
        logic en_rise;

        assign en_rise = pwr_en[d] & ~en_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                en_q         <= 1'b0;
                iso_q        <= 1'b0;
                restore_pend <= 1'b0;
            end else begin
                en_q  <= pwr_en[d];
                iso_q <= iso_en[d];
                if (ret_restore[d])
                    restore_pend <= 1'b0;
                else if (en_rise)
                    restore_pend <= 1'b1;
            end
        end

        assign off_no_iso[d] = en_q & ~pwr_en[d] & ~iso_en[d];
        assign on_no_iso[d]  = en_rise & ~iso_en[d];
        assign iso_early[d]  = iso_q & ~iso_en[d] & restore_pend;
        assign rdy_no_ack[d] = dom_ready[d] & ~pwr_ack[d];
    end

endmodule

// File: rtl/pwr_state_table.sv
module pwr_state_table #(
    parameter int NUM_DOM = 2,
    parameter int DEPTH   = 8,
    parameter int AW      = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [NUM_DOM-1:0] wr_mask,
    input  logic               wr_valid,
    input  logic [NUM_DOM-1:0] state_vec,
    output logic               legal,
    output logic [AW-1:0]      idx
);

    logic [NUM_DOM-1:0] mask_q [DEPTH];
    logic [DEPTH-1:0]   vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            for (int i = 0; i < DEPTH; i++) mask_q[i] <= '0;
        end else if (wr_en && (32'(wr_addr) < DEPTH)) begin
            vld_q[wr_addr]  <= wr_valid;
            mask_q[wr_addr] <= wr_mask;
        end
    end

    // Lowest matching entry gives the state index.
    always_comb begin
        legal = 1'b0;
        idx   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (vld_q[i] && (mask_q[i] == state_vec)) begin
                legal = 1'b1;
                idx   = AW'(i);
            end
        end
    end

endmodule

// File: rtl/pwr_cov_matrix.sv
module pwr_cov_matrix #(
    parameter int AW    = 3,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    input  logic [AW-1:0]    from_idx,
    input  logic [AW-1:0]    to_idx,
    input  logic [AW-1:0]    rd_from,
    input  logic [AW-1:0]    rd_to,
    output logic [CNT_W-1:0] rd_count
);

    localparam int NCELL = 1 << (2 * AW);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q [NCELL];
    logic [2*AW-1:0]  wr_cell;
    logic [2*AW-1:0]  rd_cell;

    assign wr_cell = {from_idx, to_idx};
    assign rd_cell = {rd_from, rd_to};

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int i = 0; i < NCELL; i++) cnt_q[i] <= '0;
        end else if (inc && (cnt_q[wr_cell] != CNT_MAX)) begin
            cnt_q[wr_cell] <= cnt_q[wr_cell] + 1'b1;
        end
    end

    assign rd_count = cnt_q[rd_cell];

endmodule

// File: rtl/pwr_seq_monitor.sv
module pwr_seq_monitor
    import pwr_seq_pkg::*;
#(
    parameter int NUM_DOM   = 2,
    parameter int TBL_DEPTH = 8,
    parameter int CNT_W     = 8,
    parameter int CYC_W     = 16,
    localparam int TBL_AW   = $clog2(TBL_DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               chk_en,
    input  logic               tbl_we,
    input  logic [TBL_AW-1:0]  tbl_addr,
    input  logic [NUM_DOM-1:0] tbl_mask,
    input  logic               tbl_valid,
    input  logic [NUM_DOM-1:0] pwr_en,
    input  logic [NUM_DOM-1:0] pwr_ack,
    input  logic [NUM_DOM-1:0] iso_en,
    input  logic [NUM_DOM-1:0] ret_restore,
    input  logic [NUM_DOM-1:0] dom_ready,
    input  logic [TBL_AW-1:0]  cov_rd_from,
    input  logic [TBL_AW-1:0]  cov_rd_to,
    output logic [NUM_ERR-1:0] err_flags,
    output logic [2:0]         err_code,
    output logic [CYC_W-1:0]   err_time,
    output logic [CNT_W-1:0]   cov_count
);

    logic [NUM_DOM-1:0] off_no_iso, on_no_iso, iso_early, rdy_no_ack;
    logic               cur_legal;
    logic [TBL_AW-1:0]  cur_idx;
    logic               prev_legal;
    logic [TBL_AW-1:0]  prev_idx;
    logic [NUM_DOM-1:0] prev_ack;
    logic               cov_inc;
    err_vec_t           ev;
    err_rec_t           rec_q;
    logic [CYC_W-1:0]   cyc_q;
    logic [CYC_W-1:0]   time_q;

    pwr_seq_rules #(.NUM_DOM(NUM_DOM)) rules_i (
        .clk        (clk),
        .rst        (rst),
        .pwr_en     (pwr_en),
        .pwr_ack    (pwr_ack),
        .iso_en     (iso_en),
        .ret_restore(ret_restore),
        .dom_ready  (dom_ready),
        .off_no_iso (off_no_iso),
        .on_no_iso  (on_no_iso),
        .iso_early  (iso_early),
        .rdy_no_ack (rdy_no_ack)
    );

    pwr_state_table #(
        .NUM_DOM(NUM_DOM),
        .DEPTH  (TBL_DEPTH),
        .AW     (TBL_AW)
    ) table_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (tbl_we & ~chk_en),
        .wr_addr  (tbl_addr),
        .wr_mask  (tbl_mask),
        .wr_valid (tbl_valid),
        .state_vec(pwr_ack),
        .legal    (cur_legal),
        .idx      (cur_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_legal <= 1'b0;
            prev_idx   <= '0;
            prev_ack   <= '0;
        end else begin
            prev_legal <= cur_legal;
            prev_idx   <= cur_idx;
            prev_ack   <= pwr_ack;
        end
    end

    assign cov_inc = chk_en & prev_legal & cur_legal & (pwr_ack != prev_ack);

    pwr_cov_matrix #(.AW(TBL_AW), .CNT_W(CNT_W)) cov_i (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .inc     (cov_inc),
        .from_idx(prev_idx),
        .to_idx  (cur_idx),
        .rd_from (cov_rd_from),
        .rd_to   (cov_rd_to),
        .rd_count(cov_count)
    );

    always_comb begin
        ev = '0;
        ev[ERR_OFF_NO_ISO] = |off_no_iso;
        ev[ERR_ON_NO_ISO]  = |on_no_iso;
        ev[ERR_ISO_EARLY]  = |iso_early;
        ev[ERR_RDY_NO_ACK] = |rdy_no_ack;
        ev[ERR_BAD_STATE]  = ~cur_legal;
        if (!chk_en) ev = '0;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rec_q  <= '0;
            cyc_q  <= '0;
            time_q <= '0;
        end else begin
            cyc_q       <= cyc_q + 1'b1;
            rec_q.flags <= rec_q.flags | ev;
            if (|ev) begin
                rec_q.code <= lowest_err(ev);
                time_q     <= cyc_q;
            end
        end
    end

    assign err_flags = rec_q.flags;
    assign err_code  = rec_q.code;
    assign err_time  = time_q;

endmodule

// File: rtl/pwr_seq_monitor_chk.sv
module pwr_seq_monitor_chk #(
    parameter int NUM_DOM = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               clr,
    input logic               chk_en,
    input logic [NUM_DOM-1:0] pwr_en,
    input logic [NUM_DOM-1:0] pwr_ack,
    input logic [NUM_DOM-1:0] iso_en,
    input logic [NUM_DOM-1:0] dom_ready,
    input logic [4:0]         err_flags,
    input logic [2:0]         err_code
);

    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

    assert_clear_R1: assert property (@(posedge clk) disable iff (rst)
        clr |=> (err_flags == '0 && err_code == '0));

    assert_disabled_R8: assert property (@(posedge clk) disable iff (rst)
        (!chk_en && !clr) |=> (err_flags == $past(err_flags)));

    assert_off_no_iso_R2: assert property (@(posedge clk) disable iff (rst)
        (chk_en && !clr && |($past(pwr_en) & ~pwr_en & ~iso_en)) |=> err_flags[0]);

    assert_on_no_iso_R3: assert property (@(posedge clk) disable iff (rst)
        (chk_en && !clr && |(~$past(pwr_en) & pwr_en & ~iso_en)) |=> err_flags[1]);

    assert_ready_no_ack_R5: assert property (@(posedge clk) disable iff (rst)
        (chk_en && !clr && |(dom_ready & ~pwr_ack)) |=> err_flags[3]);

    assert_code_needs_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (err_flags == '0) |-> (err_code == '0));

endmodule

bind pwr_seq_monitor pwr_seq_monitor_chk #(.NUM_DOM(NUM_DOM)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .chk_en   (chk_en),
    .pwr_en   (pwr_en),
    .pwr_ack  (pwr_ack),
    .iso_en   (iso_en),
    .dom_ready(dom_ready),
    .err_flags(err_flags),
    .err_code (err_code)
);

// File: tb/pwr_seq_monitor_tb_top.sv
`timescale 1ns/1ps
module pwr_seq_monitor_tb_top;

    localparam int ND = 2;

    logic       clk = 1'b0;
    logic       rst, clr, chk_en, tbl_we, tbl_valid;
    logic [2:0] tbl_addr, cov_rd_from, cov_rd_to;
    logic [1:0] tbl_mask, pwr_en, pwr_ack, iso_en, ret_restore, dom_ready;
    logic [4:0] err_flags;
    logic [2:0] err_code;
    logic [15:0] err_time;
    logic [7:0] cov_count;

    int n_chk = 0;
    int n_err = 0;
    logic [15:0] bcyc;
    logic [15:0] texp;

    always #5 clk = ~clk;

    pwr_seq_monitor dut_i (
        .clk(clk), .rst(rst), .clr(clr), .chk_en(chk_en),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_mask(tbl_mask), .tbl_valid(tbl_valid),
        .pwr_en(pwr_en), .pwr_ack(pwr_ack), .iso_en(iso_en),
        .ret_restore(ret_restore), .dom_ready(dom_ready),
        .cov_rd_from(cov_rd_from), .cov_rd_to(cov_rd_to),
        .err_flags(err_flags), .err_code(err_code), .err_time(err_time),
        .cov_count(cov_count)
    );

    // Bench cycle count: edges since last reset or clear.
    always @(posedge clk) begin
        if (rst || clr) bcyc <= '0;
        else            bcyc <= bcyc + 1'b1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic cov_read(input int f, input int t, output logic [7:0] v);
        cov_rd_from = 3'(f);
        cov_rd_to   = 3'(t);
        #1;
        v = cov_count;
    endtask

    task automatic tbl_write(input int a, input logic [1:0] m, input logic v);
        tbl_we = 1'b1; tbl_addr = 3'(a); tbl_mask = m; tbl_valid = v;
        step();
        tbl_we = 1'b0;
    endtask

    // Park domains isolated and off, restore acknowledged, then clear.
    task automatic settle();
        iso_en = 2'b11; pwr_en = 2'b00; ret_restore = 2'b11;
        dom_ready = 2'b00; pwr_ack = 2'b00;
        step();
        ret_restore = 2'b00;
        clr = 1'b1;
        step();
        clr = 1'b0;
    endtask

    function automatic logic [1:0] legal_mask(input int i);
        return (i == 0) ? 2'b00 : (i == 1) ? 2'b01 : 2'b11;
    endfunction

    logic [7:0] cv;
    logic done = 1'b0;

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; clr = 1'b0; chk_en = 1'b0; tbl_we = 1'b0; tbl_valid = 1'b0;
        tbl_addr = '0; tbl_mask = '0; pwr_en = '0; pwr_ack = '0; iso_en = '0;
        ret_restore = '0; dom_ready = '0; cov_rd_from = '0; cov_rd_to = '0;
        repeat (3) step();
        rst = 1'b0;
        step();

        // R1 reset state
        check("R1 flags", 32'(err_flags), 0);
        check("R1 code", 32'(err_code), 0);
        check("R1 time", 32'(err_time), 0);
        cov_read(0, 0, cv);
        check("R1 cov", 32'(cv), 0);

        // R9 table load while disabled; legal masks 00,01,11 at 0,1,2
        tbl_write(0, 2'b00, 1'b1);
        tbl_write(1, 2'b01, 1'b1);
        tbl_write(2, 2'b11, 1'b1);
        chk_en = 1'b1;
        tbl_write(3, 2'b10, 1'b1);   // R9: must be ignored

        // R6 exhaustive state sweep (also proves R9 write was ignored)
        for (int v = 0; v < 4; v++) begin
            settle();
            pwr_ack = 2'(v);
            step();
            check("R6 R9 illegal-state flag", 32'(err_flags), (v == 2) ? 32'h10 : 0);
            if (v == 2) check("R6 code", 32'(err_code), 4);
        end

        for (int d = 0; d < ND; d++) begin
            // R3 switch on without isolation
            settle();
            pwr_en[d] = 1'b1; iso_en[d] = 1'b0;
            texp = bcyc;
            step();
            check("R3 flags", 32'(err_flags), 32'h02);
            check("R3 code", 32'(err_code), 1);
            check("R7 time", 32'(err_time), 32'(texp));

            // R4 negative, then R2 switch off without isolation
            settle();
            pwr_en[d] = 1'b1; step();
            ret_restore[d] = 1'b1; step();
            ret_restore[d] = 1'b0;
            iso_en[d] = 1'b0; step();
            check("R4 release after restore", 32'(err_flags), 0);
            pwr_en[d] = 1'b0;
            texp = bcyc;
            step();
            check("R2 flags", 32'(err_flags), 32'h01);
            check("R2 code", 32'(err_code), 0);
            check("R7 time", 32'(err_time), 32'(texp));

            // R4 isolation released before restore
            settle();
            pwr_en[d] = 1'b1; step();
            iso_en[d] = 1'b0; step();
            check("R4 flags", 32'(err_flags), 32'h04);
            check("R4 code", 32'(err_code), 2);

            // R5 ready without ack, then with ack
            settle();
            dom_ready[d] = 1'b1; step();
            check("R5 flags", 32'(err_flags), 32'h08);
            check("R5 code", 32'(err_code), 3);
            settle();
            pwr_ack = 2'b11; dom_ready[d] = 1'b1; step();
            check("R5 ready with ack", 32'(err_flags), 0);
        end

        // R7 priority, later code update, stickiness
        settle();
        pwr_en[0] = 1'b1; iso_en[0] = 1'b0; dom_ready[1] = 1'b1;
        step();
        check("R7 paired flags", 32'(err_flags), 32'h0A);
        check("R7 paired code", 32'(err_code), 1);
        dom_ready[1] = 1'b0; dom_ready[0] = 1'b1;
        texp = bcyc;
        step();
        dom_ready[0] = 1'b0;
        check("R7 later code", 32'(err_code), 3);
        check("R7 later time", 32'(err_time), 32'(texp));
        repeat (3) step();
        check("R7 sticky", 32'(err_flags), 32'h0A);
        check("R7 time held", 32'(err_time), 32'(texp));

        // R1 clear
        clr = 1'b1; step(); clr = 1'b0;
        check("R1 clr flags", 32'(err_flags), 0);
        check("R1 clr code", 32'(err_code), 0);
        check("R1 clr time", 32'(err_time), 0);

        // R8 disabled: violations and transitions ignored
        settle();
        chk_en = 1'b0;
        pwr_en[0] = 1'b1; iso_en[0] = 1'b0; dom_ready = 2'b11; pwr_ack = 2'b10;
        step();
        pwr_ack = 2'b00; dom_ready = 2'b00; step();
        pwr_ack = 2'b01; step();
        check("R8 flags", 32'(err_flags), 0);
        cov_read(0, 1, cv);
        check("R8 cov", 32'(cv), 0);
        chk_en = 1'b1;

        // R10 R11 all ordered pairs of legal states
        for (int a = 0; a < 3; a++) begin
            for (int b = 0; b < 3; b++) begin
                if (a != b) begin
                    settle();
                    pwr_ack = legal_mask(a);
                    clr = 1'b1; step(); clr = 1'b0;
                    pwr_ack = legal_mask(b); step();
                    pwr_ack = legal_mask(a); step();
                    pwr_ack = legal_mask(b); step();
                    cov_read(a, b, cv);
                    check("R10 forward count", 32'(cv), 2);
                    cov_read(b, a, cv);
                    check("R10 return count", 32'(cv), 1);
                    cov_read(a, a, cv);
                    check("R11 unselected cell", 32'(cv), 0);
                end
            end
        end

        // R10 transitions through an illegal vector not counted
        settle();
        pwr_ack = 2'b10; step();
        pwr_ack = 2'b11; step();
        cov_read(0, 2, cv);
        check("R10 illegal path", 32'(cv), 0);
        check("R6 illegal seen", 32'(err_flags[4]), 1);

        // R10 saturation
        settle();
        pwr_ack = 2'b01;
        clr = 1'b1; step(); clr = 1'b0;
        for (int k = 0; k < 300; k++) begin
            pwr_ack = 2'b00; step();
            pwr_ack = 2'b01; step();
        end
        cov_read(1, 0, cv);
        check("R10 saturate down", 32'(cv), 255);
        cov_read(0, 1, cv);
        check("R10 saturate up", 32'(cv), 255);
        cov_read(2, 1, cv);
        check("R11 other cell", 32'(cv), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule